// File: doc/BRIEF.md
# Prioritized Interrupt Claim Core

This block sits between a set of interrupt gateways and a set of interrupt targets. Each gateway raises a request line. The core keeps one pending flag per source. It holds a priority for every source, and an enable mask and a threshold for every target. From this state it drives a level notification to each target. That level is high while the target has work that beats its threshold.

A target services work by issuing a claim. The claim hands back the ID of the most urgent source the target may see, and the same clock edge clears that source's pending flag. Once the target has finished, it writes a completion carrying the source ID. The core passes that completion on to the matching gateway, but only when the source is enabled for that target.

Configuration uses a single write port. The number of sources, the number of targets and the priority width are all parameters.

Top module: `irq_claim_core`

## Requirements
- R1: Source IDs run from 1 to N_SRC, and ID 0 means "none". A claim on target t (claim_req bit t high for one cycle) places the winning ID on that target's claim_id field at the next clock edge. The field holds its value until the next claim. It reads 0 when no source qualifies.
- R2: A source whose priority is 0 never raises a notification and is never returned by a claim.
- R3: Among qualifying sources with equal priority, the claim returns the one with the smaller ID.
- R4: eip bit t is a combinational function of the core state. It is high exactly when some source is pending, is enabled for t, and has a priority strictly greater than t's threshold. A threshold of 0 masks nothing.
- R5: gw_req bit s-1 belongs to source ID s. A high request sets that source's pending flag only while the flag is clear. Further requests while it is pending have no effect, so exactly one claim is satisfied.
- R6: A claim clears the pending flag of the source it returns, on the same edge. No other target can claim that same request afterwards, including another target claiming in the same cycle.
- R7: After a claim, eip stays high if other qualifying sources are still pending for that target.
- R8: Notification is multicast. Every target evaluates its own enable mask and threshold against the shared pending flags.
- R9: A completion from target t (cmpl_we bit t, ID in t's cmpl_id field) produces a one-cycle pulse on gw_done bit ID-1 at the next edge. This happens only if that source is enabled for t; otherwise nothing is sent.
- R10: When several targets claim in the same cycle, they are served in order of increasing target index. A later target sees the flags already cleared by an earlier one.
- R11: Configuration writes happen when cfg_we is high. cfg_kind 0 writes the priority of source cfg_idx (IDs 1..N_SRC) from the low PRIO_W bits of cfg_wdata. cfg_kind 1 writes the enable mask of target cfg_idx, with data bit s-1 enabling ID s. cfg_kind 2 writes the threshold of target cfg_idx. Every bit pattern of a priority or threshold is a legal level. All state resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gw_req | input | N_SRC | Request lines from the gateways, bit s-1 for ID s |
| gw_done | output | N_SRC | Completion pulses to the gateways |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 priority, 1 enable mask, 2 threshold |
| cfg_idx | input | IDX_W | Source ID or target index of the write |
| cfg_wdata | input | CFG_W | Write data |
| claim_req | input | N_TGT | Claim strobe per target |
| claim_id | output | N_TGT*ID_W | Claimed ID per target, registered |
| cmpl_we | input | N_TGT | Completion strobe per target |
| cmpl_id | input | N_TGT*ID_W | Completed ID per target |
| eip | output | N_TGT | Pending notification per target |

## Verification
The hardest case to reach is two targets claiming in the same cycle, because the second result depends on a pending flag that the first claim clears on that very edge. The bench gets there by loading two sources of different priority, giving both targets open enables and a zero threshold, and raising both claim strobes together. It then repeats the test with only one source pending, so the higher-index target has to come back empty. Completion gating is reached by giving one target a narrow enable mask and completing a source outside that mask.

// File: rtl/icc_pkg.sv
// Shared definitions for the interrupt claim core.
// Assumes: cfg_kind ports carry one of the codes below; other codes are ignored.
package icc_pkg;
    typedef enum logic [1:0] {
        CFG_PRIO   = 2'd0,
        CFG_ENABLE = 2'd1,
        CFG_THRESH = 2'd2
    } cfg_kind_e;

    // Returns the larger of two integers, used for derived port widths.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/icc_config.sv
// Configuration store: priority per source, enable mask and threshold per
// target. Every bit of each field is writable, so any value is a legal level.
// Assumes: cfg_idx selects a source ID (1..N_SRC) for priority writes and a
// target index (0..N_TGT-1) for enable and threshold writes.
module icc_config
    import icc_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int N_TGT  = 2,
    parameter int PRIO_W = 3,
    parameter int IDX_W  = 4,
    parameter int CFG_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [1:0]                cfg_kind,
    input  logic [IDX_W-1:0]          cfg_idx,
    input  logic [CFG_W-1:0]          cfg_wdata,
    output logic [N_SRC*PRIO_W-1:0]   prio_flat,
    output logic [N_TGT*N_SRC-1:0]    en_flat,
    output logic [N_TGT*PRIO_W-1:0]   thr_flat
);
    cfg_kind_e kind;
    assign kind = cfg_kind_e'(cfg_kind);

    for (genvar s = 0; s < N_SRC; s++) begin : g_prio
        // Store the priority of source ID s+1.
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_flat[s*PRIO_W +: PRIO_W] <= '0;
            else if (cfg_we && kind == CFG_PRIO && cfg_idx == IDX_W'(s + 1))
                prio_flat[s*PRIO_W +: PRIO_W] <= cfg_wdata[PRIO_W-1:0];
        end
    end

    for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
        // Store the enable mask of target t.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_flat[t*N_SRC +: N_SRC] <= '0;
            else if (cfg_we && kind == CFG_ENABLE && cfg_idx == IDX_W'(t))
                en_flat[t*N_SRC +: N_SRC] <= cfg_wdata[N_SRC-1:0];
        end

        // Store the threshold of target t.
        always_ff @(posedge clk) begin
            if (!rst_n)
                thr_flat[t*PRIO_W +: PRIO_W] <= '0;
            else if (cfg_we && kind == CFG_THRESH && cfg_idx == IDX_W'(t))
                thr_flat[t*PRIO_W +: PRIO_W] <= cfg_wdata[PRIO_W-1:0];
        end
    end
endmodule

// File: rtl/icc_claim_arb.sv
// Claim arbiter: for every target, finds the highest-priority pending and
// enabled source above the target threshold; ties go to the lower ID.
// Targets are served in order of increasing index, and a claiming target
// removes its winner from what later targets can see.
// Assumes: pend is the registered pending vector; clr is applied at the edge.
module icc_claim_arb #(
    parameter int N_SRC  = 8,
    parameter int N_TGT  = 2,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 4
) (
    input  logic [N_SRC-1:0]          pend,
    input  logic [N_TGT-1:0]          claim_req,
    input  logic [N_TGT*N_SRC-1:0]    en_flat,
    input  logic [N_SRC*PRIO_W-1:0]   prio_flat,
    input  logic [N_TGT*PRIO_W-1:0]   thr_flat,
    output logic [N_TGT*ID_W-1:0]     win_flat,
    output logic [N_SRC-1:0]          clr
);
    // Sequential scan: targets in index order, sources in ascending ID.
    always_comb begin
        logic [N_SRC-1:0]  taken;
        logic [PRIO_W-1:0] best_p;
        logic [ID_W-1:0]   best_id;
        logic [N_SRC-1:0]  best_hot;
        taken    = '0;
        win_flat = '0;
        for (int t = 0; t < N_TGT; t++) begin
            best_p   = thr_flat[t*PRIO_W +: PRIO_W];
            best_id  = '0;
            best_hot = '0;
            for (int s = 0; s < N_SRC; s++) begin
                if (pend[s] && !taken[s] && en_flat[t*N_SRC + s] &&
                    prio_flat[s*PRIO_W +: PRIO_W] > best_p) begin
                    best_p   = prio_flat[s*PRIO_W +: PRIO_W];
                    best_id  = ID_W'(s + 1);
                    best_hot = '0;
                    best_hot[s] = 1'b1;
                end
            end
            win_flat[t*ID_W +: ID_W] = best_id;
            if (claim_req[t])
                taken = taken | best_hot;
        end
        clr = taken;
    end
endmodule

// File: rtl/icc_notify.sv
// Notification for one target: high when any pending, enabled source has a
// priority strictly above the target threshold.
// Assumes: inputs are registered core state; the output is combinational.
module icc_notify #(
    parameter int N_SRC  = 8,
    parameter int PRIO_W = 3
) (
    input  logic [N_SRC-1:0]          pend,
    input  logic [N_SRC-1:0]          en,
    input  logic [N_SRC*PRIO_W-1:0]   prio_flat,
    input  logic [PRIO_W-1:0]         thr,
    output logic                      eip
);
    logic [N_SRC-1:0] above;

    for (genvar s = 0; s < N_SRC; s++) begin : g_cmp
        assign above[s] = prio_flat[s*PRIO_W +: PRIO_W] > thr;
    end

    // Reduce the qualifying sources to one level.
    always_comb eip = |(pend & en & above);
endmodule

// File: rtl/icc_complete.sv
// Completion router: turns per-target completion writes into one-cycle
// pulses towards the gateways, dropping any for a source the target has
// not enabled.
// Assumes: ID 0 or IDs above N_SRC match no source and are dropped.
module icc_complete #(
    parameter int N_SRC = 8,
    parameter int N_TGT = 2,
    parameter int ID_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_TGT-1:0]          cmpl_we,
    input  logic [N_TGT*ID_W-1:0]     cmpl_id,
    input  logic [N_TGT*N_SRC-1:0]    en_flat,
    output logic [N_SRC-1:0]          gw_done
);
    logic [N_SRC-1:0] hit;

    // Decode the completions that pass the enable gate.
    always_comb begin
        hit = '0;
        for (int t = 0; t < N_TGT; t++) begin
            for (int s = 0; s < N_SRC; s++) begin
                if (cmpl_we[t] && cmpl_id[t*ID_W +: ID_W] == ID_W'(s + 1) &&
                    en_flat[t*N_SRC + s])
                    hit[s] = 1'b1;
            end
        end
    end

    // Register the pulses towards the gateways.
    always_ff @(posedge clk) begin
        if (!rst_n) gw_done <= '0;
        else        gw_done <= hit;
    end
endmodule

// File: rtl/irq_claim_core.sv
// Prioritized interrupt claim core: pending flags, configuration store,
// per-target notification, atomic claims and gated completions.
// Assumes: gateways hold or pulse gw_req; one claim and one completion per
// target per cycle at most.
module irq_claim_core
    import icc_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int N_TGT  = 2,
    parameter int PRIO_W = 3,
    localparam int ID_W  = $clog2(N_SRC + 1),
    localparam int TGT_W = (N_TGT > 1) ? $clog2(N_TGT) : 1,
    localparam int IDX_W = imax(ID_W, TGT_W),
    localparam int CFG_W = imax(N_SRC, PRIO_W)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SRC-1:0]          gw_req,
    output logic [N_SRC-1:0]          gw_done,
    input  logic                      cfg_we,
    input  logic [1:0]                cfg_kind,
    input  logic [IDX_W-1:0]          cfg_idx,
    input  logic [CFG_W-1:0]          cfg_wdata,
    input  logic [N_TGT-1:0]          claim_req,
    output logic [N_TGT*ID_W-1:0]     claim_id,
    input  logic [N_TGT-1:0]          cmpl_we,
    input  logic [N_TGT*ID_W-1:0]     cmpl_id,
    output logic [N_TGT-1:0]          eip
);
    logic [N_SRC-1:0]          pend_q;
    logic [N_SRC-1:0]          clr;
    logic [N_SRC*PRIO_W-1:0]   prio_flat;
    logic [N_TGT*N_SRC-1:0]    en_flat;
    logic [N_TGT*PRIO_W-1:0]   thr_flat;
    logic [N_TGT*ID_W-1:0]     win_flat;

    icc_config #(
        .N_SRC(N_SRC), .N_TGT(N_TGT), .PRIO_W(PRIO_W),
        .IDX_W(IDX_W), .CFG_W(CFG_W)
    ) u_config (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .prio_flat(prio_flat), .en_flat(en_flat), .thr_flat(thr_flat)
    );

    icc_claim_arb #(
        .N_SRC(N_SRC), .N_TGT(N_TGT), .PRIO_W(PRIO_W), .ID_W(ID_W)
    ) u_arb (
        .pend(pend_q), .claim_req(claim_req), .en_flat(en_flat),
        .prio_flat(prio_flat), .thr_flat(thr_flat),
        .win_flat(win_flat), .clr(clr)
    );

    icc_complete #(
        .N_SRC(N_SRC), .N_TGT(N_TGT), .ID_W(ID_W)
    ) u_complete (
        .clk(clk), .rst_n(rst_n), .cmpl_we(cmpl_we), .cmpl_id(cmpl_id),
        .en_flat(en_flat), .gw_done(gw_done)
    );

    // Pending flags: accept a request only into a clear flag, drop claimed ones.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | (gw_req & ~pend_q);
    end

    for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
        icc_notify #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_notify (
            .pend(pend_q), .en(en_flat[t*N_SRC +: N_SRC]),
            .prio_flat(prio_flat), .thr(thr_flat[t*PRIO_W +: PRIO_W]),
            .eip(eip[t])
        );

        // Capture the claim result of target t.
        always_ff @(posedge clk) begin
            if (!rst_n)
                claim_id[t*ID_W +: ID_W] <= '0;
            else if (claim_req[t])
                claim_id[t*ID_W +: ID_W] <= win_flat[t*ID_W +: ID_W];
        end
    end
endmodule

// File: rtl/irq_claim_core_checker.sv
// Property checker for the interrupt claim core, bound to every instance.
// Assumes: pend_q is the core's internal pending vector.
module irq_claim_core_checker #(
    parameter int N_SRC = 8,
    parameter int N_TGT = 2,
    parameter int ID_W  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_SRC-1:0]        gw_req,
    input logic [N_SRC-1:0]        pend_q,
    input logic [N_TGT-1:0]        claim_req,
    input logic [N_TGT*ID_W-1:0]   claim_id,
    input logic [N_TGT-1:0]        cmpl_we,
    input logic [N_TGT-1:0]        eip,
    input logic [N_SRC-1:0]        gw_done
);
    logic [N_SRC-1:0] pend_prev;
    logic [N_TGT-1:0] claim_prev;

    // Keep the previous pending vector and claim strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_prev  <= '0;
            claim_prev <= '0;
        end else begin
            pend_prev  <= pend_q;
            claim_prev <= claim_req;
        end
    end

    AST_PEND_SET_BY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~$past(gw_req)) == '0)); // R5

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0) |-> (eip == '0)); // R4

    AST_DONE_NEEDS_CMPL: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_done != '0) |-> $past(cmpl_we != '0)); // R9

    for (genvar t = 0; t < N_TGT; t++) begin : g_t
        AST_CLAIM_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            (claim_prev[t] && claim_id[t*ID_W +: ID_W] != '0)
                |-> pend_prev[claim_id[t*ID_W +: ID_W] - 1'b1]); // R6
    end

    if (N_TGT > 1) begin : g_pair
        AST_NO_DUP_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
            (claim_prev[0] && claim_prev[1] &&
             claim_id[0 +: ID_W] == claim_id[ID_W +: ID_W])
                |-> (claim_id[0 +: ID_W] == '0)); // R10
    end
endmodule

bind irq_claim_core irq_claim_core_checker #(
    .N_SRC(N_SRC), .N_TGT(N_TGT), .ID_W(ID_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .gw_req(gw_req), .pend_q(pend_q),
    .claim_req(claim_req), .claim_id(claim_id), .cmpl_we(cmpl_we),
    .eip(eip), .gw_done(gw_done)
);

// File: tb/test_irq_claim_core.sv
// Bench: table of vectors for target 0 arbitration, then directed tests.
// Source priorities by ID 1..8: 1,3,3,0,5,2,5,7.
module test_irq_claim_core;
    localparam int N_SRC = 8;
    localparam int N_TGT = 2;
    localparam int ID_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_SRC-1:0] gw_req = '0;
    logic [N_SRC-1:0] gw_done;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_kind = '0;
    logic [3:0] cfg_idx = '0;
    logic [7:0] cfg_wdata = '0;
    logic [N_TGT-1:0] claim_req = '0;
    logic [N_TGT*ID_W-1:0] claim_id;
    logic [N_TGT-1:0] cmpl_we = '0;
    logic [N_TGT*ID_W-1:0] cmpl_id = '0;
    logic [N_TGT-1:0] eip;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    irq_claim_core #(.N_SRC(N_SRC), .N_TGT(N_TGT), .PRIO_W(3)) i_irq_claim_core (
        .clk(clk), .rst_n(rst_n), .gw_req(gw_req), .gw_done(gw_done),
        .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .claim_req(claim_req), .claim_id(claim_id),
        .cmpl_we(cmpl_we), .cmpl_id(cmpl_id), .eip(eip)
    );

    // {req[7:0], en0[7:0], thr0[2:0], eip0, id[3:0]}
    localparam logic [23:0] VEC [10] = '{
        {8'h01, 8'hFF, 3'd0, 1'b1, 4'd1},  // R4 threshold 0
        {8'h06, 8'hFF, 3'd0, 1'b1, 4'd2},  // R3 tie
        {8'h08, 8'hFF, 3'd0, 1'b0, 4'd0},  // R2 priority 0
        {8'h50, 8'hFF, 3'd4, 1'b1, 4'd5},  // R3 tie above thr
        {8'h50, 8'hFF, 3'd5, 1'b0, 4'd0},  // R4 strict
        {8'h81, 8'h01, 3'd0, 1'b1, 4'd1},  // R11 enable mask
        {8'hFF, 8'h00, 3'd0, 1'b0, 4'd0},  // R1 none enabled
        {8'hFF, 8'hFF, 3'd6, 1'b1, 4'd8},  // R11 max priority
        {8'h22, 8'hFF, 3'd2, 1'b1, 4'd2},  // R4
        {8'h20, 8'hFF, 3'd2, 1'b0, 4'd0}   // R4 equal to thr
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] kind, input logic [3:0] idx, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = kind; cfg_idx = idx; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic raise(input logic [7:0] mask);
        @(negedge clk);
        gw_req = mask;
        @(negedge clk);
        gw_req = '0;
    endtask

    task automatic claim(input int t, output logic [3:0] id);
        @(negedge clk);
        claim_req[t] = 1'b1;
        @(negedge clk);
        claim_req = '0;
        id = claim_id[t*ID_W +: ID_W];
    endtask

    task automatic claim_both(output logic [3:0] id0, output logic [3:0] id1);
        @(negedge clk);
        claim_req = 2'b11;
        @(negedge clk);
        claim_req = '0;
        id0 = claim_id[0 +: ID_W];
        id1 = claim_id[ID_W +: ID_W];
    endtask

    task automatic complete(input int t, input logic [3:0] id);
        @(negedge clk);
        cmpl_we[t] = 1'b1;
        cmpl_id[t*ID_W +: ID_W] = id;
        @(negedge clk);
        cmpl_we = '0;
        cmpl_id = '0;
    endtask

    // Empty every pending flag through target 0.
    task automatic drain();
        logic [3:0] id;
        cfg(2'd0, 4'd4, 8'd1);
        cfg(2'd1, 4'd0, 8'hFF);
        cfg(2'd2, 4'd0, 8'd0);
        for (int k = 0; k < N_SRC; k++) claim(0, id);
        cfg(2'd0, 4'd4, 8'd0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [3:0] a;
        logic [3:0] b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R11, R1)
        check(32'(eip), 0, "R11 reset eip");
        check(32'(gw_done), 0, "R11 reset gw_done");
        check(32'(claim_id), 0, "R1 reset claim_id");
        claim(0, a);
        check(32'(a), 0, "R1 claim with nothing pending");

        // Priorities by ID (R11)
        cfg(2'd0, 4'd1, 8'd1); cfg(2'd0, 4'd2, 8'd3);
        cfg(2'd0, 4'd3, 8'd3); cfg(2'd0, 4'd4, 8'd0);
        cfg(2'd0, 4'd5, 8'd5); cfg(2'd0, 4'd6, 8'd2);
        cfg(2'd0, 4'd7, 8'd5); cfg(2'd0, 4'd8, 8'd7);

        for (int v = 0; v < 10; v++) begin
            drain();
            raise(VEC[v][23:16]);
            cfg(2'd1, 4'd0, VEC[v][15:8]);
            cfg(2'd2, 4'd0, 8'(VEC[v][7:5]));
            check(32'(eip[0]), 32'(VEC[v][4]), $sformatf("R4 vector %0d eip", v));
            claim(0, a);
            check(32'(a), 32'(VEC[v][3:0]), $sformatf("R1 R3 vector %0d id", v));
        end

        // R8 multicast with separate thresholds
        drain();
        cfg(2'd1, 4'd1, 8'hFF);
        cfg(2'd2, 4'd1, 8'd1);
        raise(8'h01);
        check(32'(eip), 32'h1, "R8 only target 0 above thr");
        raise(8'h02);
        check(32'(eip), 32'h3, "R8 both targets notified");

        // R10 same-cycle claims, lower index first
        cfg(2'd2, 4'd1, 8'd0);
        claim_both(a, b);
        check(32'(a), 2, "R10 target 0 wins first");
        check(32'(b), 1, "R10 target 1 gets next");
        raise(8'h10);
        claim_both(a, b);
        check(32'(a), 5, "R6 target 0 takes single");
        check(32'(b), 0, "R6 target 1 cannot reclaim");

        // R7 eip remains while work is left
        drain();
        raise(8'h22);
        claim(0, a);
        check(32'(a), 2, "R7 first claim");
        check(32'(eip[0]), 1, "R7 eip still high");
        claim(0, a);
        check(32'(a), 6, "R7 second claim");
        check(32'(eip[0]), 0, "R7 eip low after last");

        // R5 repeated request while pending
        raise(8'h04);
        raise(8'h04);
        claim(0, a);
        check(32'(a), 3, "R5 claim once");
        claim(0, a);
        check(32'(a), 0, "R5 no second request");

        // R9 completion gating
        cfg(2'd1, 4'd1, 8'h01);
        complete(1, 4'd3);
        check(32'(gw_done), 0, "R9 disabled source dropped");
        complete(1, 4'd1);
        check(32'(gw_done), 32'h01, "R9 enabled source forwarded");
        @(negedge clk);
        check(32'(gw_done), 0, "R9 pulse one cycle");
        complete(0, 4'd3);
        check(32'(gw_done), 32'h04, "R9 target 0 forwards ID 3");

        summary();
        $finish;
    end
endmodule